// File: doc/BRIEF.md
# Winternitz Hash Chain Engine

This block is a SHA-256 compression engine that can also walk a complete Winternitz hash chain without outside help. It serves the one-time-signature step of hash-based signature verification. In plain mode it compresses one caller-padded 512-bit block per command. An `init_i` strobe starts from the standard initial value. A `next_i` strobe continues from the chaining value left by the previous block. A mode input selects the SHA-224 initial value and shortened output.

In chain mode the caller supplies one padded block. That block holds a 22-byte fixed prefix (a 16-byte identifier, a 4-byte leaf index and a 2-byte chain index), a starting coefficient and the starting value. The engine then hashes repeatedly. After each step it writes the step index and the n-byte running value back into a block that it builds and pads itself. When the chain reaches its top coefficient it returns the final value with a single `digest_valid_o` pulse. The value width n is 32 bytes, or 24 bytes using SHA-256 truncated to 192 bits.

Top module: `sha_wc_engine`

## Requirements
- R1: After reset, `ready_o` is 1, `digest_o` is 0, `digest_valid_o` is 0 and `error_o` is 0.
- R2: An `init_i` strobe alone (chain mode off, `sha224_i`=0) compresses `block_i` from the SHA-256 initial value. `digest_valid_o` goes high 66 rising edges after the edge that samples the strobe, and `digest_o` then holds the result, with word 0 in bits 255:224.
- R3: A `next_i` strobe alone compresses `block_i` starting from the chaining value left by the previous compression, so two commands give the two-block SHA-256 result.
- R4: With `sha224_i`=1 the SHA-224 initial value is used, and bits 31:0 of `digest_o` read as zero.
- R5: In chain mode, step j hashes a 64-byte block with this byte layout (byte k = bits 511-8k down to 504-8k): bytes 0–21 are the prefix taken from `block_i`, byte 22 is j, and bytes 23 onward are the running value. For n=32 these are followed by 0x80 at byte 55 and the 64-bit big-endian length 440 in bytes 56–63. The starting coefficient a is read from byte 22 of `block_i`, and the starting value from bytes 23 onward.
- R6: With coefficient width w, the chain runs j = a … 2^w−2. Each step is a fresh SHA-256 from the initial value whose (truncated) digest becomes the next running value. The final running value appears on `digest_o`, with `digest_valid_o` high 67·(2^w−1−a) edges after the command edge.
- R7: With `n24_i`=1 the running value is 24 bytes: 0x80 sits at byte 47, the length field is 376, every step digest is truncated to its upper 192 bits, and `digest_o[63:0]` reads as zero.
- R8: If a ≥ 2^w−1, no hashing is done. The (truncated) starting value is returned with `digest_valid_o` high one edge after the command edge.
- R9: A chain command whose `coef_w_i` is not 1, 2, 4 or 8 is ignored: `ready_o` stays 1, `digest_o` is unchanged, and `error_o` becomes 2'b01.
- R10: `init_i` and `next_i` together are ignored: `ready_o` stays 1, `digest_o` is unchanged, and `error_o` becomes 2'b10. An accepted command clears `error_o` to 0.
- R11: `ready_o` is low from the edge that accepts a command until `digest_valid_o` rises. Strobes seen while busy are ignored, and `digest_valid_o` lasts one cycle.
- R12: `zeroize_i` aborts any work and clears all state: `ready_o` becomes 1, `digest_o` becomes 0, no `digest_valid_o` follows, and the chaining value used by a later `next_i` is all zero.
- R13: The chain sequencer starts the compression core only when the core is idle, and otherwise waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| zeroize_i | input | 1 | Clears all state and aborts work |
| init_i | input | 1 | Start strobe from the initial value |
| next_i | input | 1 | Continue strobe from the last chaining value |
| sha224_i | input | 1 | Plain mode: 1 selects SHA-224 |
| chain_en_i | input | 1 | Run a Winternitz chain on the strobe |
| coef_w_i | input | 4 | Coefficient width w (1, 2, 4, 8) |
| n24_i | input | 1 | 1: 24-byte values, 0: 32-byte values |
| block_i | input | 512 | Padded block or chain seed block |
| ready_o | output | 1 | Idle and able to take a command |
| digest_o | output | 256 | Result value |
| digest_valid_o | output | 1 | One-cycle result pulse |
| error_o | output | 2 | Bit 1: strobe collision; bit 0: bad w |

## Verification
The assertions assume that the strobes and mode inputs are sampled only while `ready_o` is high, and that reset is asserted from time zero. They also assume that a zeroize pulse is a plain synchronous clear that no other command overlaps. The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. It injects busy-time strobes and zeroize only at chosen points. Each expected digest comes from an arithmetic SHA-256 model in the bench, with known-answer vectors anchoring that model. The chain sweep covers every starting coefficient for w = 1, 2 and 4 at both value widths, and all twelve illegal w codes.

// File: rtl/sha_wc_pkg.sv
package sha_wc_pkg;
  localparam int WORD_W  = 32;
  localparam int BLK_W   = 512;
  localparam int DIG_W   = 256;
  localparam int N_WORDS = DIG_W / WORD_W;
  localparam int SCHED_N = BLK_W / WORD_W;
  localparam int ROUNDS  = 64;
  localparam int RND_W   = $clog2(ROUNDS);
  localparam int J_W     = 8;
  localparam int PRE_W   = 176;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [0:ROUNDS-1][WORD_W-1:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  localparam logic [0:N_WORDS-1][WORD_W-1:0] IV_256 = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [0:N_WORDS-1][WORD_W-1:0] IV_224 = {
    32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
    32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction
  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction
  function automatic word_t sm_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction
  function automatic word_t sm_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha_wc_round.sv
module sha_wc_round
  import sha_wc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             zeroize,
  input  logic             start,
  input  logic             use_iv,
  input  logic             short_iv,
  input  logic [BLK_W-1:0] blk,
  output logic             idle,
  output logic             done,
  output logic [DIG_W-1:0] chain_val
);
  typedef enum logic [1:0] {C_IDLE, C_RND, C_FIN} cst_t;

  cst_t             cst;
  logic [RND_W-1:0] rnd;
  word_t            wk    [N_WORDS];
  word_t            hv    [N_WORDS];
  word_t            sched [SCHED_N];
  word_t            t1, t2, sched_nx;

  always_comb begin
    t1 = wk[7] + big_s1(wk[4]) + ((wk[4] & wk[5]) ^ (~wk[4] & wk[6])) + K_TAB[rnd] + sched[0];
    t2 = big_s0(wk[0]) + ((wk[0] & wk[1]) ^ (wk[0] & wk[2]) ^ (wk[1] & wk[2]));
    sched_nx = sm_s1(sched[14]) + sched[9] + sm_s0(sched[1]) + sched[0];
    for (int i = 0; i < N_WORDS; i++) chain_val[DIG_W-1-WORD_W*i -: WORD_W] = hv[i];
  end

  assign idle = (cst == C_IDLE);

  always_ff @(posedge clk) begin
    if (rst || zeroize) begin
      cst  <= C_IDLE;
      rnd  <= '0;
      done <= 1'b0;
      for (int i = 0; i < N_WORDS; i++) begin wk[i] <= '0; hv[i] <= '0; end
      for (int i = 0; i < SCHED_N; i++) sched[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (cst)
        C_IDLE: if (start) begin
          for (int i = 0; i < N_WORDS; i++) begin
            if (use_iv) begin
              wk[i] <= short_iv ? IV_224[i] : IV_256[i];
              hv[i] <= short_iv ? IV_224[i] : IV_256[i];
            end else begin
              wk[i] <= hv[i];
            end
          end
          for (int i = 0; i < SCHED_N; i++) sched[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
          rnd <= '0;
          cst <= C_RND;
        end
        C_RND: begin
          wk[0] <= t1 + t2;
          wk[1] <= wk[0];
          wk[2] <= wk[1];
          wk[3] <= wk[2];
          wk[4] <= wk[3] + t1;
          wk[5] <= wk[4];
          wk[6] <= wk[5];
          wk[7] <= wk[6];
          for (int i = 0; i < SCHED_N-1; i++) sched[i] <= sched[i+1];
          sched[SCHED_N-1] <= sched_nx;
          rnd <= rnd + 1'b1;
          if (rnd == RND_W'(ROUNDS-1)) cst <= C_FIN;
        end
        C_FIN: begin
          for (int i = 0; i < N_WORDS; i++) hv[i] <= hv[i] + wk[i];
          done <= 1'b1;
          cst  <= C_IDLE;
        end
        default: cst <= C_IDLE;
      endcase
    end
  end

  assert_start_idle_R13: assert property (@(posedge clk) disable iff (rst)
    start |-> idle);
  assert_done_after_final_R2: assert property (@(posedge clk) disable iff (rst || zeroize)
    done |-> $past(cst == C_FIN));
  assert_final_after_last_round_R2: assert property (@(posedge clk) disable iff (rst || zeroize)
    (cst == C_FIN) |-> $past(cst == C_RND && rnd == RND_W'(ROUNDS-1)));
endmodule

// File: rtl/sha_wc_engine.sv
module sha_wc_engine
  import sha_wc_pkg::*;
#(
  parameter int COEF_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zeroize_i,
  input  logic              init_i,
  input  logic              next_i,
  input  logic              sha224_i,
  input  logic              chain_en_i,
  input  logic [COEF_W-1:0] coef_w_i,
  input  logic              n24_i,
  input  logic [BLK_W-1:0]  block_i,
  output logic              ready_o,
  output logic [DIG_W-1:0]  digest_o,
  output logic              digest_valid_o,
  output logic [1:0]        error_o
);
  localparam int J_LSB = BLK_W - 8 * 23;
  localparam int Y_LSB32 = J_LSB - 256;
  localparam int Y_LSB24 = J_LSB - 192;

  typedef enum logic [2:0] {T_IDLE, T_HASH, T_GO, T_WAIT, T_SKIP} tst_t;

  tst_t             st;
  logic [PRE_W-1:0] prefix_q;
  logic [J_W-1:0]   j_q, jlast_q, a_in, jmax;
  logic [J_W:0]     jmax_w;
  logic [DIG_W-1:0] y_q, core_dig, trunc_dig;
  logic [BLK_W-1:0] step_blk, core_blk;
  logic             n24_q, m224_q, strobe, both, w_ok, accept_norm;
  logic             core_start, core_idle, core_done, core_iv, core_short;

  assign strobe  = init_i | next_i;
  assign both    = init_i & next_i;
  assign w_ok    = (coef_w_i == 1) || (coef_w_i == 2) || (coef_w_i == 4) || (coef_w_i == 8);
  assign jmax_w  = ((J_W+1)'(1) << coef_w_i) - (J_W+1)'(1);
  assign jmax    = jmax_w[J_W-1:0];
  assign a_in    = block_i[J_LSB +: J_W];
  assign ready_o = (st == T_IDLE);
  assign accept_norm = (st == T_IDLE) && strobe && !both && !chain_en_i;

  always_comb begin
    step_blk = '0;
    step_blk[BLK_W-1 -: PRE_W] = prefix_q;
    step_blk[J_LSB +: J_W]     = j_q;
    if (n24_q) begin
      step_blk[Y_LSB24 +: 192]   = y_q[DIG_W-1 -: 192];
      step_blk[Y_LSB24-1 -: 8]   = 8'h80;
      step_blk[63:0]             = 64'd376;
    end else begin
      step_blk[Y_LSB32 +: 256]   = y_q;
      step_blk[Y_LSB32-1 -: 8]   = 8'h80;
      step_blk[63:0]             = 64'd440;
    end
  end

  assign core_start = accept_norm || (st == T_GO && core_idle);
  assign core_blk   = (st == T_GO) ? step_blk : block_i;
  assign core_iv    = (st == T_GO) || init_i;
  assign core_short = (st == T_GO) ? 1'b0 : sha224_i;
  assign trunc_dig  = n24_q ? {core_dig[DIG_W-1:64], 64'd0} : core_dig;

  sha_wc_round i_round (
    .clk(clk), .rst(rst), .zeroize(zeroize_i), .start(core_start),
    .use_iv(core_iv), .short_iv(core_short), .blk(core_blk),
    .idle(core_idle), .done(core_done), .chain_val(core_dig));

  always_ff @(posedge clk) begin
    if (rst || zeroize_i) begin
      st <= T_IDLE; prefix_q <= '0; j_q <= '0; jlast_q <= '0; y_q <= '0;
      n24_q <= 1'b0; m224_q <= 1'b0; digest_o <= '0; digest_valid_o <= 1'b0; error_o <= '0;
    end else begin
      digest_valid_o <= 1'b0;
      unique case (st)
        T_IDLE: if (strobe) begin
          if (both) error_o <= 2'b10;
          else if (chain_en_i && !w_ok) error_o <= 2'b01;
          else begin
            error_o <= 2'b00;
            if (chain_en_i) begin
              prefix_q <= block_i[BLK_W-1 -: PRE_W];
              j_q      <= a_in;
              jlast_q  <= jmax;
              n24_q    <= n24_i;
              y_q      <= n24_i ? {block_i[Y_LSB24 +: 192], 64'd0} : block_i[Y_LSB32 +: 256];
              st       <= (a_in >= jmax) ? T_SKIP : T_GO;
            end else begin
              m224_q <= sha224_i;
              st     <= T_HASH;
            end
          end
        end
        T_HASH: if (core_done) begin
          digest_o       <= m224_q ? {core_dig[DIG_W-1:32], 32'd0} : core_dig;
          digest_valid_o <= 1'b1;
          st             <= T_IDLE;
        end
        T_GO: if (core_idle) st <= T_WAIT;
        T_WAIT: if (core_done) begin
          y_q <= trunc_dig;
          j_q <= j_q + 1'b1;
          if (J_W'(j_q + 1'b1) == jlast_q) begin
            digest_o       <= trunc_dig;
            digest_valid_o <= 1'b1;
            st             <= T_IDLE;
          end else begin
            st <= T_GO;
          end
        end
        T_SKIP: begin
          digest_o       <= y_q;
          digest_valid_o <= 1'b1;
          st             <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    digest_valid_o |=> !digest_valid_o);
  assert_valid_when_ready_R11: assert property (@(posedge clk) disable iff (rst)
    digest_valid_o |-> ready_o);
  assert_collision_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (ready_o && init_i && next_i && !zeroize_i) |=> (ready_o && error_o == 2'b10));
  assert_bad_w_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (ready_o && (init_i ^ next_i) && chain_en_i && !w_ok && !zeroize_i) |=> (ready_o && error_o == 2'b01));
  assert_zeroize_clears_R12: assert property (@(posedge clk) disable iff (rst)
    zeroize_i |=> (ready_o && digest_o == '0 && !digest_valid_o && error_o == 2'b00));
  assert_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (st == T_WAIT) |-> (j_q < jlast_q));
endmodule

// File: tb/test_sha_wc_engine.sv
module test_sha_wc_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         zeroize_i = 1'b0, init_i = 1'b0, next_i = 1'b0, sha224_i = 1'b0;
  logic         chain_en_i = 1'b0, n24_i = 1'b0;
  logic [3:0]   coef_w_i = 4'd4;
  logic [511:0] block_i = '0;
  logic         ready_o, digest_valid_o;
  logic [255:0] digest_o;
  logic [1:0]   error_o;

  int n_vec = 0, n_bad = 0, cyc = 0;

  localparam logic [255:0] H256 = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  sha_wc_engine i_sha_wc_engine (
    .clk(clk), .rst(rst), .zeroize_i(zeroize_i), .init_i(init_i), .next_i(next_i),
    .sha224_i(sha224_i), .chain_en_i(chain_en_i), .coef_w_i(coef_w_i), .n24_i(n24_i),
    .block_i(block_i), .ready_o(ready_o), .digest_o(digest_o),
    .digest_valid_o(digest_valid_o), .error_o(error_o));

  always #2.5ns clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: run hung act=%0d exp<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_compress(input logic [255:0] hin, input logic [511:0] b);
    logic [31:0] w [0:63];
    logic [31:0] v [0:7];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
    for (int i = 0; i < 64; i++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6]))
         + sha_wc_pkg::K_TAB[i] + w[i];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [511:0] ref_step(input logic [175:0] pre, input int j,
                                            input logic [255:0] y, input bit n24);
    logic [7:0]   by [0:63];
    logic [63:0]  len;
    logic [511:0] r;
    int nb;
    nb = n24 ? 24 : 32;
    for (int k = 0; k < 64; k++) by[k] = 8'h00;
    for (int k = 0; k < 22; k++) by[k] = pre[175-8*k -: 8];
    by[22] = 8'(j);
    for (int k = 0; k < nb; k++) by[23+k] = y[255-8*k -: 8];
    by[23+nb] = 8'h80;
    len = 64'((23 + nb) * 8);
    for (int k = 0; k < 8; k++) by[56+k] = len[63-8*k -: 8];
    for (int k = 0; k < 64; k++) r[511-8*k -: 8] = by[k];
    return r;
  endfunction

  function automatic logic [255:0] ref_chain(input logic [175:0] pre, input int a, input int w,
                                             input bit n24, input logic [255:0] y0);
    logic [255:0] y, d;
    y = y0;
    for (int j = a; j < (1 << w) - 1; j++) begin
      d = ref_compress(H256, ref_step(pre, j, y, n24));
      y = n24 ? {d[255:64], 64'd0} : d;
    end
    return y;
  endfunction

  function automatic logic [511:0] rand512();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  task automatic run_cmd(input bit ini, input bit nxt, input bit ch, input logic [3:0] w,
                         input bit n24, input bit m224, input logic [511:0] b,
                         output int lat, output bit rdy_low);
    @(negedge clk);
    init_i = ini; next_i = nxt; chain_en_i = ch; coef_w_i = w; n24_i = n24; sha224_i = m224; block_i = b;
    @(posedge clk); lat = 1;
    @(negedge clk);
    init_i = 1'b0; next_i = 1'b0;
    rdy_low = !ready_o;
    while (!digest_valid_o && lat < 30000) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lat;
    bit rl;
    logic [511:0] b, b2;
    logic [255:0] exp, held, y0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_o && digest_o == '0 && !digest_valid_o && error_o == 2'b00, "R1 reset state",
        {ready_o, digest_valid_o, error_o, digest_o[251:0]}, 256'h8 << 252);

    // R2: known answer "abc" and latency
    b = {32'h61626380, 416'b0, 64'h18};
    run_cmd(1, 0, 0, 4'd4, 0, 0, b, lat, rl);
    chk(digest_o == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
        "R2 sha256 known answer", digest_o, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    chk(lat == 67, "R2 latency edges+1", 256'(lat), 256'd67);
    chk(rl, "R11 ready low after accept", 256'(rl), 256'd1);
    @(negedge clk);
    chk(!digest_valid_o, "R11 valid single cycle", 256'(digest_valid_o), 256'd0);

    // R4: SHA-224 known answer
    run_cmd(1, 0, 0, 4'd4, 0, 1, b, lat, rl);
    chk(digest_o == {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 32'd0},
        "R4 sha224 known answer", digest_o, {224'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da7, 32'd0});

    // R3: two-block continuation, several random patterns
    for (int t = 0; t < 4; t++) begin
      b = rand512(); b2 = rand512();
      run_cmd(1, 0, 0, 4'd4, 0, 0, b, lat, rl);
      chk(digest_o == ref_compress(H256, b), "R2 random block", digest_o, ref_compress(H256, b));
      run_cmd(0, 1, 0, 4'd4, 0, 0, b2, lat, rl);
      exp = ref_compress(ref_compress(H256, b), b2);
      chk(digest_o == exp, "R3 next continuation", digest_o, exp);
    end

    // R11: strobes while busy are ignored
    b = rand512(); b2 = rand512();
    @(negedge clk); init_i = 1; chain_en_i = 0; sha224_i = 0; block_i = b;
    @(negedge clk); init_i = 0;
    repeat (10) @(negedge clk);
    init_i = 1; block_i = b2;
    @(negedge clk); init_i = 0; next_i = 1;
    @(negedge clk); next_i = 0;
    lat = 0;
    while (!digest_valid_o && lat < 1000) begin @(negedge clk); lat++; end
    chk(digest_o == ref_compress(H256, b), "R11 busy strobes ignored", digest_o, ref_compress(H256, b));
    @(negedge clk);
    chk(!digest_valid_o && ready_o, "R11 no second result", 256'(digest_valid_o), 256'd0);

    // R5 R6 R7 R8: sweep every starting coefficient for w = 1, 2, 4 at both value widths
    for (int nsel = 0; nsel < 2; nsel++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w, mx;
        w = 1 << wi; mx = (1 << w) - 1;
        for (int a = 0; a <= mx; a++) begin
          int k;
          b = rand512();
          b[335:328] = 8'(a);
          y0 = nsel ? {b[327:136], 64'd0} : b[327:72];
          exp = ref_chain(b[511:336], a, w, nsel[0], y0);
          k = mx - a;
          run_cmd(1, 0, 1, 4'(w), nsel[0], 0, b, lat, rl);
          chk(digest_o == exp, nsel ? "R7 chain n24 result" : "R5 R6 chain n32 result", digest_o, exp);
          chk(lat == ((k == 0) ? 2 : 67 * k + 1), (k == 0) ? "R8 skip latency" : "R6 chain latency",
              256'(lat), 256'((k == 0) ? 2 : 67 * k + 1));
          if (nsel == 1) chk(digest_o[63:0] == 64'd0, "R7 low bytes zero", digest_o, exp);
        end
      end
    end

    // R8: coefficient above the top returns the start value
    b = rand512(); b[335:328] = 8'd9;
    run_cmd(0, 1, 1, 4'd2, 0, 0, b, lat, rl);
    chk(digest_o == b[327:72] && lat == 2, "R8 coefficient above top", digest_o, b[327:72]);

    // R6: w = 8 near the top
    b = rand512(); b[335:328] = 8'd251;
    exp = ref_chain(b[511:336], 251, 8, 0, b[327:72]);
    run_cmd(1, 0, 1, 4'd8, 0, 0, b, lat, rl);
    chk(digest_o == exp && lat == 67 * 4 + 1, "R6 w8 chain", digest_o, exp);

    // R9: every illegal coefficient width
    held = digest_o;
    for (int w = 0; w < 16; w++) begin
      if (w != 1 && w != 2 && w != 4 && w != 8) begin
        @(negedge clk); init_i = 1; chain_en_i = 1; coef_w_i = 4'(w); block_i = rand512();
        @(negedge clk); init_i = 0;
        chk(ready_o && error_o == 2'b01 && digest_o == held, "R9 bad w ignored",
            {error_o, ready_o, digest_o[252:0]}, {2'b01, 1'b1, held[252:0]});
        repeat (2) @(negedge clk);
        chk(!digest_valid_o && ready_o, "R9 no result after bad w", 256'(digest_valid_o), 256'd0);
      end
    end

    // R10: init and next together
    @(negedge clk); init_i = 1; next_i = 1; chain_en_i = 0; block_i = rand512();
    @(negedge clk); init_i = 0; next_i = 0;
    chk(ready_o && error_o == 2'b10 && digest_o == held, "R10 collision ignored",
        {error_o, digest_o[253:0]}, {2'b10, held[253:0]});
    b = rand512();
    run_cmd(1, 0, 0, 4'd4, 0, 0, b, lat, rl);
    chk(error_o == 2'b00 && digest_o == ref_compress(H256, b), "R10 error cleared by accept",
        256'(error_o), 256'd0);

    // R12: zeroize mid-chain, then continuation from an all-zero chaining value
    b = rand512(); b[335:328] = 8'd0;
    @(negedge clk); init_i = 1; chain_en_i = 1; coef_w_i = 4'd4; n24_i = 0; block_i = b;
    @(negedge clk); init_i = 0;
    repeat (100) @(negedge clk);
    zeroize_i = 1;
    @(negedge clk); zeroize_i = 0;
    chk(ready_o && digest_o == '0 && error_o == 2'b00, "R12 zeroize clears", digest_o, 256'd0);
    lat = 0;
    for (int t = 0; t < 300; t++) begin @(negedge clk); if (digest_valid_o) lat++; end
    chk(lat == 0, "R12 no result after zeroize", 256'(lat), 256'd0);
    b2 = rand512();
    run_cmd(0, 1, 0, 4'd4, 0, 0, b2, lat, rl);
    chk(digest_o == ref_compress(256'd0, b2), "R12 chaining value zeroed", digest_o, ref_compress(256'd0, b2));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule